// File: doc/BRIEF.md
# Sync Polarity Normalizer and Interlace Field Detector

The block accepts separate horizontal and vertical sync inputs of either polarity. It first passes each input through a two-stage synchronizer. It then inverts the input where required, so that both syncs come out active-high: the pulse's leading edge becomes a rising edge. The normalized syncs drive the block's outputs and feed a leading-edge detector for each channel.

To decide which field of an interlaced frame is in progress, the block generates a delayed copy of each horizontal leading edge. The delay is set in microseconds, from 0 to 63, and is counted at four clock cycles per microsecond. It should match the time constant, taken modulo one 64 us line, that the external chassis uses when it integrates vertical sync. When a vertical leading edge arrives, the block measures how far into the current delayed line that edge falls. The field flag is set when the edge lands in the first half of that line and cleared otherwise. Software chooses the two polarities and the delay once for a given chassis.

Top module: `syncfld_top`

## Requirements
- R1: While reset is asserted and for the cycle after it, the field flag is 0. With both polarity bits at 1 and both raw syncs low, both normalized outputs are 0.
- R2: With the horizontal polarity bit at 1, the normalized horizontal output follows the raw input. With the bit at 0, the output is the raw input inverted.
- R3: The vertical polarity bit acts on the vertical channel in the same way as in R2, and a vertical leading edge is reported for exactly one cycle.
- R4: A change on a raw sync appears on its normalized output after exactly two rising clock edges.
- R5: A delayed horizontal edge occurs 4·D clock cycles after each horizontal leading edge, where D is the delay setting. A vertical leading edge that falls 0 to 127 cycles after the most recent delayed edge sets the field flag to 1.
- R6: A vertical leading edge that falls 128 or more cycles after the most recent delayed edge sets the field flag to 0.
- R7: With delay 0, the delayed edge coincides with the horizontal leading edge, so edges that arrive in the same cycle give field 1.
- R8: The line position saturates at 511 cycles. A vertical leading edge that arrives while no delayed edge has occurred for that long (for example, before the pending delayed edge fires) gives field 0.
- R9: The field flag changes only in the cycle after a vertical leading edge. Horizontal activity alone leaves it unchanged.
- R10: A new horizontal leading edge restarts any delay count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz timing clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncRaw | input | 1 | Raw horizontal sync |
| vsyncRaw | input | 1 | Raw vertical sync |
| hPolPos | input | 1 | 1: horizontal leading edge is rising; 0: falling |
| vPolPos | input | 1 | 1: vertical leading edge is rising; 0: falling |
| hDelayUs | input | 6 | Horizontal delay in microseconds (0..63) |
| hsyncNorm | output | 1 | Active-high synchronized horizontal sync |
| vsyncNorm | output | 1 | Active-high synchronized vertical sync |
| fieldOdd | output | 1 | 1 when the last vertical edge fell in the first half of the delayed line |

## Verification
The assertions assume that the polarity bits and the delay setting are static, or change only while no edge is pending. They also assume that each sync pulse lasts at least one cycle between a leading and a trailing edge, so that every leading edge is separated by a return to idle. The stimulus sets polarity and delay during a long idle gap before each pattern. It drives every pulse for at least three cycles and starts each field pattern after more than 511 idle cycles, so the line position is known to be saturated when the pattern begins.

// File: rtl/syncfld_pkg.sv
package syncfld_pkg;
  typedef struct packed {
    logic hLead;
    logic vLead;
  } edgeStrb_t;
endpackage

// File: rtl/syncfld_chan.sv
module syncfld_chan #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic polPos,
  output logic normOut,
  output logic leadOut
);
  logic [STAGES-1:0] pipeQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) pipeQ <= '0;
    else       pipeQ <= {pipeQ[STAGES-2:0], rawIn};
  end

  // Active-high form of the synchronized input
  assign normOut = polPos ? pipeQ[STAGES-1] : ~pipeQ[STAGES-1];

  // Previous level resets high so no edge is reported straight out of reset
  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= normOut;
  end

  assign leadOut = normOut & ~prevQ;
endmodule

// File: rtl/syncfld_ctrl.sv
module syncfld_ctrl
  import syncfld_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hsyncRaw,
  input  logic      vsyncRaw,
  input  logic      hPolPos,
  input  logic      vPolPos,
  output logic      hsyncNorm,
  output logic      vsyncNorm,
  output edgeStrb_t strb
);
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] rawV;
  logic [NUM_CH-1:0] polV;
  logic [NUM_CH-1:0] normV;
  logic [NUM_CH-1:0] leadV;

  assign rawV = {vsyncRaw, hsyncRaw};
  assign polV = {vPolPos, hPolPos};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    syncfld_chan #(.STAGES(SYNC_STAGES)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawV[g]),
      .polPos (polV[g]),
      .normOut(normV[g]),
      .leadOut(leadV[g])
    );
  end

  assign hsyncNorm  = normV[0];
  assign vsyncNorm  = normV[1];
  assign strb.hLead = leadV[0];
  assign strb.vLead = leadV[1];
endmodule

// File: rtl/syncfld_datapath.sv
module syncfld_datapath
  import syncfld_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int DELAY_W     = 6,
  parameter int LINE_US     = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  edgeStrb_t          strb,
  input  logic [DELAY_W-1:0] hDelayUs,
  output logic               dLead,
  output logic               fieldOdd
);
  localparam int LINE_CYC = LINE_US * CLKS_PER_US;
  localparam int HALF_CYC = LINE_CYC / 2;
  localparam int CNT_W    = $clog2((1 << DELAY_W) * CLKS_PER_US);
  localparam int POS_W    = $clog2(2 * LINE_CYC);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [CNT_W-1:0] targetCyc;
  logic [CNT_W-1:0] cntQ;
  logic             armedQ;
  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] effPos;
  logic             fieldQ;

  assign targetCyc = CNT_W'(hDelayUs) * CNT_W'(CLKS_PER_US);

  // Delay counter: restarted by every horizontal leading edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      cntQ   <= '0;
    end else if (strb.hLead) begin
      armedQ <= (targetCyc != '0);
      cntQ   <= CNT_W'(1);
    end else if (armedQ) begin
      if (cntQ >= targetCyc) armedQ <= 1'b0;
      else                   cntQ   <= cntQ + 1'b1;
    end
  end

  assign dLead = (strb.hLead && (targetCyc == '0)) ||
                 (!strb.hLead && armedQ && (cntQ >= targetCyc));

  // Position within the delayed line, saturating
  always_ff @(posedge clk) begin
    if (!rstN)             posQ <= POS_MAX;
    else if (dLead)        posQ <= POS_W'(1);
    else if (posQ != POS_MAX) posQ <= posQ + 1'b1;
  end

  assign effPos = dLead ? '0 : posQ;

  always_ff @(posedge clk) begin
    if (!rstN)           fieldQ <= 1'b0;
    else if (strb.vLead) fieldQ <= (effPos < POS_W'(HALF_CYC));
  end

  assign fieldOdd = fieldQ;
endmodule

// File: rtl/syncfld_top.sv
module syncfld_top
  import syncfld_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int DELAY_W     = 6,
  parameter int LINE_US     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncRaw,
  input  logic               vsyncRaw,
  input  logic               hPolPos,
  input  logic               vPolPos,
  input  logic [DELAY_W-1:0] hDelayUs,
  output logic               hsyncNorm,
  output logic               vsyncNorm,
  output logic               fieldOdd
);
  edgeStrb_t strb;
  logic      dLead;

  syncfld_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hsyncRaw (hsyncRaw),
    .vsyncRaw (vsyncRaw),
    .hPolPos  (hPolPos),
    .vPolPos  (vPolPos),
    .hsyncNorm(hsyncNorm),
    .vsyncNorm(vsyncNorm),
    .strb     (strb)
  );

  syncfld_datapath #(
    .CLKS_PER_US(CLKS_PER_US),
    .DELAY_W    (DELAY_W),
    .LINE_US    (LINE_US)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .hDelayUs(hDelayUs),
    .dLead   (dLead),
    .fieldOdd(fieldOdd)
  );
endmodule

// File: rtl/syncfld_checker.sv
module syncfld_checker #(
  parameter int DELAY_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               hsyncRaw,
  input logic               vsyncRaw,
  input logic               hPolPos,
  input logic               vPolPos,
  input logic [DELAY_W-1:0] hDelayUs,
  input logic               hsyncNorm,
  input logic               vsyncNorm,
  input logic               fieldOdd,
  input logic               hLead,
  input logic               vLead,
  input logic               dLead
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end

  if (SYNC_STAGES == 2) begin : g_lat
    p_hnorm_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd2) |-> (hsyncNorm == (hPolPos ? $past(hsyncRaw, 2) : ~$past(hsyncRaw, 2))));
    p_vnorm_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd2) |-> (vsyncNorm == (vPolPos ? $past(vsyncRaw, 2) : ~$past(vsyncRaw, 2))));
  end

  p_field_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !vLead |=> $stable(fieldOdd));

  p_delay_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hLead && (hDelayUs == '0)) |-> dLead);

  p_coincident_first_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vLead && dLead) |=> fieldOdd);

  p_vlead_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    vLead |=> !vLead);
endmodule

bind syncfld_top syncfld_checker #(
  .DELAY_W    (DELAY_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hsyncRaw (hsyncRaw),
  .vsyncRaw (vsyncRaw),
  .hPolPos  (hPolPos),
  .vPolPos  (vPolPos),
  .hDelayUs (hDelayUs),
  .hsyncNorm(hsyncNorm),
  .vsyncNorm(vsyncNorm),
  .fieldOdd (fieldOdd),
  .hLead    (strb.hLead),
  .vLead    (strb.vLead),
  .dLead    (dLead)
);

// File: tb/test_syncfld_top.sv
module test_syncfld_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       hLvl, vLvl;
  logic       hPol, vPol;
  logic [5:0] hDly;
  logic       hsyncRaw, vsyncRaw;
  logic       hsyncNorm, vsyncNorm, fieldOdd;
  int         nChecks = 0;
  int         nFails  = 0;
  bit         done    = 1'b0;

  always #2 clk = ~clk;

  // Raw level is the logical pulse level, inverted when polarity is negative
  assign hsyncRaw = hLvl ^ ~hPol;
  assign vsyncRaw = vLvl ^ ~vPol;

  syncfld_top i_syncfld_top (
    .clk      (clk),
    .rstN     (rstN),
    .hsyncRaw (hsyncRaw),
    .vsyncRaw (vsyncRaw),
    .hPolPos  (hPol),
    .vPolPos  (vPol),
    .hDelayUs (hDly),
    .hsyncNorm(hsyncNorm),
    .vsyncNorm(vsyncNorm),
    .fieldOdd (fieldOdd)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // One pattern: horizontal pulses at h1 and h2, vertical pulse at v (-1: none)
  task automatic runPattern(int h1, int h2, int v);
    int last;
    last = (v > h2) ? v : h2;
    if (h1 > last) last = h1;
    cyc(600);
    for (int t = 0; t <= last + 10; t++) begin
      hLvl = ((h1 >= 0) && t >= h1 && t < h1 + 3) || ((h2 >= 0) && t >= h2 && t < h2 + 3);
      vLvl = (v >= 0) && t >= v && t < v + 3;
      cyc(1);
    end
    hLvl = 1'b0;
    vLvl = 1'b0;
  endtask

  task automatic fieldCase(string req, int dly, int h2, int v, int expField);
    hDly = 6'(dly);
    runPattern(0, h2, v);
    check(req, int'(fieldOdd), expField);
  endtask

  task automatic testReset();
    check("R1 hsyncNorm in reset", int'(hsyncNorm), 0);
    check("R1 vsyncNorm in reset", int'(vsyncNorm), 0);
    check("R1 fieldOdd in reset", int'(fieldOdd), 0);
    rstN = 1'b1;
    cyc(1);
    check("R1 fieldOdd after reset", int'(fieldOdd), 0);
  endtask

  task automatic testPolarity(bit hp, bit vp);
    hPol = hp;
    vPol = vp;
    cyc(5);
    check("R2 hsyncNorm idle", int'(hsyncNorm), 0);
    check("R3 vsyncNorm idle", int'(vsyncNorm), 0);
    hLvl = 1'b1;
    vLvl = 1'b1;
    cyc(1);
    check("R4 hsyncNorm after one edge", int'(hsyncNorm), 0);
    check("R4 vsyncNorm after one edge", int'(vsyncNorm), 0);
    cyc(1);
    check("R2 hsyncNorm active", int'(hsyncNorm), 1);
    check("R3 vsyncNorm active", int'(vsyncNorm), 1);
    hLvl = 1'b0;
    vLvl = 1'b0;
    cyc(2);
    check("R2 hsyncNorm released", int'(hsyncNorm), 0);
    check("R3 vsyncNorm released", int'(vsyncNorm), 0);
  endtask

  task automatic testHold();
    fieldCase("R5 setup for hold", 0, -1, 10, 1);
    runPattern(0, 30, -1);
    check("R9 field kept at 1 with only hsync", int'(fieldOdd), 1);
    fieldCase("R6 setup for hold", 0, -1, 200, 0);
    runPattern(0, -1, -1);
    check("R9 field kept at 0 with only hsync", int'(fieldOdd), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    hLvl = 1'b0;
    vLvl = 1'b0;
    hPol = 1'b1;
    vPol = 1'b1;
    hDly = '0;
    cyc(4);
    testReset();
    testPolarity(1'b1, 1'b1);
    testPolarity(1'b0, 1'b0);
    testPolarity(1'b1, 1'b0);
    hPol = 1'b1;
    vPol = 1'b1;
    fieldCase("R7 delay 0 coincident edges", 0, -1, 0, 1);
    fieldCase("R5 delay 0 offset 127", 0, -1, 127, 1);
    fieldCase("R6 delay 0 offset 128", 0, -1, 128, 0);
    fieldCase("R5 delay 5 offset 0", 5, -1, 20, 1);
    fieldCase("R8 vsync before delayed edge", 5, -1, 19, 0);
    fieldCase("R5 delay 63 offset 50", 63, -1, 302, 1);
    fieldCase("R6 delay 63 offset 130", 63, -1, 382, 0);
    fieldCase("R10 restart keeps offset 127", 10, 20, 187, 1);
    fieldCase("R10 restart offset 128", 10, 20, 188, 0);
    hPol = 1'b0;
    vPol = 1'b0;
    fieldCase("R5 negative polarity offset 10", 2, -1, 18, 1);
    fieldCase("R6 negative polarity offset 200", 2, -1, 208, 0);
    hPol = 1'b1;
    vPol = 1'b1;
    testHold();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule